// File: doc/BRIEF.md
# Serial 0-1-0 Pattern Detector with Overlap Select

This block watches a serial bit stream, taking one bit on each rising clock edge, and raises a single-cycle flag when the last three bits form the pattern zero, one, zero. The flag is a Mealy output. It rises in the same cycle as the closing zero is presented, so no extra register delay is added. A neighbour can sample it on the same edge that takes that bit in.

A mode input picks how successive matches relate. In overlapping mode, the closing zero of one match also serves as the opening zero of the next. In consuming mode, the three bits of a match are used up, and a new match needs three fresh bits. The mode is expected to be set while reset is held. Behaviour after a mode change is defined only from the next reset onward. A parameter selects a binary or a one-hot state register. Both encodings give the same behaviour at the ports.

Top module: `pat010_detector`

## Requirements
- R1: While rst_i is high, match_o is 0. A high rst_i at a rising edge returns the machine to its idle state, so a match afterwards needs a full fresh 0,1,0.
- R2: match_o is 1 in the cycle where bit_i is 0, the two bits taken on the previous two edges were 0 then 1, and (in consuming mode) none of those three bits belonged to an earlier match.
- R3: In any other cycle, match_o is 0. In particular, match_o is never 1 in two consecutive cycles.
- R4: With overlap_i = 1, the closing 0 of a match opens the next one. The stream 0,1,0,1,0 gives exactly two matches, on the 3rd and 5th bits.
- R5: With overlap_i = 0, the bits of a match are consumed. The stream 0,1,0,1,0 gives exactly one match, on the 3rd bit, and 0,1,0,0,1,0 gives two matches.
- R6: Any run of 0s keeps the machine ready for a 1. For example, 0,0,0,1,0 gives one match, on the 5th bit.
- R7: A 1 that follows 0,1 discards the partial pattern. For example, 0,1,1,0 gives no match, and a match then needs a new 1 followed by a 0.
- R8: The binary (STATE_ENC = 0) and one-hot (STATE_ENC = 1) state encodings produce identical match_o for identical input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes occur on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial data bit, taken on each rising edge |
| overlap_i | input | 1 | 1 = overlapping matches, 0 = consuming matches |
| match_o | output | 1 | Mealy flag: 1 while the present bit completes 0,1,0 |

## Verification
Every 8-bit stream is applied in both modes, starting from reset, to a binary-encoded and a one-hot-encoded instance. Each cycle's flag is compared with a value worked out in the bench from the last three bits and the end position of the previous match. That sweep covers the corner cases where overlapping and consuming modes differ, such as 01010 and 0101010, and it also covers runs of zeros, discarded partial patterns and patterns at the stream's edges. Directed streams count matches on the examples given in the requirements. A reset raised while the machine holds 0,1 shows that the flag is held low during reset and that the partial pattern is lost.

// File: rtl/pat010_pkg.sv
package pat010_pkg;

   localparam int unsigned NUM_STATES = 4;
   localparam int unsigned STATE_W    = $clog2(NUM_STATES);

   localparam int unsigned ENC_BINARY = 0;
   localparam int unsigned ENC_ONEHOT = 1;

   // Progress through the pattern; SPENT follows a consumed match.
   typedef enum logic [STATE_W-1:0] {
      ST_IDLE  = 2'd0,
      ST_GOT0  = 2'd1,
      ST_GOT01 = 2'd2,
      ST_SPENT = 2'd3
   } det_state_e;

endpackage

// File: rtl/pat010_next.sv
module pat010_next
   import pat010_pkg::*;
(
   input  det_state_e cur_st,
   input  logic       bit_i,
   input  logic       overlap_i,
   output det_state_e nxt_st
);

   always_comb begin
      nxt_st = ST_IDLE;
      unique case (cur_st)
         ST_IDLE:  nxt_st = bit_i ? ST_IDLE : ST_GOT0;
         ST_GOT0:  nxt_st = bit_i ? ST_GOT01 : ST_GOT0;
         ST_GOT01: begin
            if (bit_i)          nxt_st = ST_IDLE;
            else if (overlap_i) nxt_st = ST_GOT0;
            else                nxt_st = ST_SPENT;
         end
         ST_SPENT: nxt_st = bit_i ? ST_IDLE : ST_GOT0;
         default:  nxt_st = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/pat010_streg.sv
module pat010_streg
   import pat010_pkg::*;
#(
   parameter int unsigned STATE_ENC = ENC_BINARY
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  det_state_e nxt_st,
   output det_state_e cur_st
);

   generate
      if (STATE_ENC == ENC_BINARY) begin : g_bin
         logic [STATE_W-1:0] q;
         always_ff @(posedge clk_i) begin
            if (rst_i) q <= ST_IDLE;
            else       q <= nxt_st;
         end
         assign cur_st = det_state_e'(q);
      end else begin : g_hot
         localparam logic [NUM_STATES-1:0] ONE = NUM_STATES'(1);
         logic [NUM_STATES-1:0] q;
         always_ff @(posedge clk_i) begin
            if (rst_i) q <= ONE << ST_IDLE;
            else       q <= ONE << nxt_st;
         end
         always_comb begin
            cur_st = ST_IDLE;
            for (int k = 0; k < NUM_STATES; k++) begin
               if (q[k]) cur_st = det_state_e'(k[STATE_W-1:0]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pat010_out.sv
module pat010_out
   import pat010_pkg::*;
(
   input  logic       rst_i,
   input  det_state_e cur_st,
   input  logic       bit_i,
   output logic       match_o
);

   // Mealy decode: holding 0,1 and the present bit is 0.
   always_comb begin
      match_o = 1'b0;
      if (!rst_i && cur_st == ST_GOT01 && !bit_i) match_o = 1'b1;
   end

endmodule

// File: rtl/pat010_detector.sv
module pat010_detector
   import pat010_pkg::*;
#(
   parameter int unsigned STATE_ENC = ENC_BINARY
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic bit_i,
   input  logic overlap_i,
   output logic match_o
);

   generate
      if (STATE_ENC != ENC_BINARY && STATE_ENC != ENC_ONEHOT) begin : g_bad_enc
         $error("pat010_detector: STATE_ENC must be 0 or 1");
      end
   endgenerate

   det_state_e cur_st;
   det_state_e nxt_st;

   pat010_next u_next (
      .cur_st    (cur_st),
      .bit_i     (bit_i),
      .overlap_i (overlap_i),
      .nxt_st    (nxt_st)
   );

   pat010_streg #(.STATE_ENC(STATE_ENC)) u_streg (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .nxt_st (nxt_st),
      .cur_st (cur_st)
   );

   pat010_out u_out (
      .rst_i   (rst_i),
      .cur_st  (cur_st),
      .bit_i   (bit_i),
      .match_o (match_o)
   );

endmodule

// File: rtl/pat010_chk.sv
module pat010_chk
   import pat010_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       bit_in,
   input logic       ovl,
   input logic       match,
   input det_state_e st
);

   // R1
   rst_quiet_chk: assert property (@(posedge clk) rst |-> !match);

   // R1
   rst_idle_chk: assert property (@(posedge clk) rst |=> st == ST_IDLE);

   // R2
   match_history_chk: assert property (@(posedge clk) disable iff (rst)
      match |-> (!bit_in && $past(bit_in) && !$past(bit_in, 2)));

   // R3
   match_gap_chk: assert property (@(posedge clk) disable iff (rst)
      match |=> !match);

   // R4
   ovl_resume_chk: assert property (@(posedge clk) disable iff (rst)
      (match && ovl) |=> st == ST_GOT0);

   // R5
   consume_chk: assert property (@(posedge clk) disable iff (rst)
      (match && !ovl) |=> st == ST_SPENT);

   // R6
   zero_run_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_GOT0 && !bit_in) |=> st == ST_GOT0);

   // R7
   discard_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_GOT01 && bit_in) |=> st == ST_IDLE);

endmodule

bind pat010_detector pat010_chk u_chk (
   .clk    (clk_i),
   .rst    (rst_i),
   .bit_in (bit_i),
   .ovl    (overlap_i),
   .match  (match_o),
   .st     (cur_st)
);

// File: tb/pat010_detector_tb.sv
`timescale 1ns/100ps
module pat010_detector_tb;

   logic clk_i = 1'b0;
   logic rst_i = 1'b1;
   logic bit_i = 1'b0;
   logic overlap_i = 1'b0;
   logic match_bin;
   logic match_hot;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk_i = ~clk_i;

   pat010_detector #(.STATE_ENC(0)) u_dut (
      .clk_i(clk_i), .rst_i(rst_i), .bit_i(bit_i),
      .overlap_i(overlap_i), .match_o(match_bin));

   pat010_detector #(.STATE_ENC(1)) u_dut_hot (
      .clk_i(clk_i), .rst_i(rst_i), .bit_i(bit_i),
      .overlap_i(overlap_i), .match_o(match_hot));

   task automatic chk(input logic got, input logic exp, input string tag);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: match_o=%b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk_i);
      rst_i = 1'b1;
      overlap_i = mode;
      bit_i = 1'b0;
      #1;
      chk(match_bin, 1'b0, "R1 reset bin");
      chk(match_hot, 1'b0, "R1 reset hot");
   endtask

   // Presents one bit, returns the binary instance's flag
   task automatic step(input logic b, output logic got);
      @(negedge clk_i);
      rst_i = 1'b0;
      bit_i = b;
      #1;
      got = match_bin;
   endtask

   // Streams bits [len-1] first, counts matches
   task automatic count_run(input logic mode, input int len, input logic [15:0] pat,
                            input int exp_cnt, input string tag);
      int cnt = 0;
      logic g;
      do_reset(mode);
      for (int i = len - 1; i >= 0; i--) begin
         step(pat[i], g);
         if (g) cnt++;
      end
      n_tests++;
      if (cnt != exp_cnt) begin
         n_fail++;
         $display("FAIL %s: %0d matches expected %0d", tag, cnt, exp_cnt);
      end
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic g;
      logic e;
      int   last;
      logic [7:0] v;

      do_reset(1'b0);

      // Exhaustive sweep over 8-bit streams in both modes
      for (int mode = 0; mode < 2; mode++) begin
         for (int s = 0; s < 256; s++) begin
            v = 8'(s);
            last = -100;
            do_reset(mode[0]);
            for (int i = 0; i < 8; i++) begin
               e = 1'b0;
               if (i >= 2 && !v[i-2] && v[i-1] && !v[i]) begin
                  if (mode == 1 || (i - 2) > last) begin
                     e = 1'b1;
                     last = i;
                  end
               end
               step(v[i], g);
               if (e)         chk(g, e, "R2 sweep");
               else if (mode == 1) chk(g, e, "R3 sweep overlap");
               else           chk(g, e, "R3 sweep consume");
               chk(match_hot, e, "R8 one-hot sweep");
            end
         end
      end

      // Directed examples
      count_run(1'b1, 5, 16'b01010,  2, "R4 overlap 01010");
      count_run(1'b1, 7, 16'b0101010, 3, "R4 overlap 0101010");
      count_run(1'b0, 5, 16'b01010,  1, "R5 consume 01010");
      count_run(1'b0, 6, 16'b010010, 2, "R5 consume 010010");
      count_run(1'b0, 7, 16'b0101010, 2, "R5 consume 0101010");
      count_run(1'b0, 5, 16'b00010,  1, "R6 zero run");
      count_run(1'b1, 4, 16'b0110,   0, "R7 discard 0110");
      count_run(1'b1, 6, 16'b011010, 1, "R7 discard then match");

      // Reset while holding 0,1: flag low, partial pattern lost
      do_reset(1'b1);
      step(1'b0, g);
      step(1'b1, g);
      @(negedge clk_i);
      rst_i = 1'b1;
      bit_i = 1'b0;
      #1;
      chk(match_bin, 1'b0, "R1 mid reset bin");
      chk(match_hot, 1'b0, "R1 mid reset hot");
      step(1'b0, g); chk(g, 1'b0, "R1 after reset");
      step(1'b1, g); chk(g, 1'b0, "R1 after reset");
      step(1'b0, g); chk(g, 1'b1, "R2 after reset");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule